// File: doc/BRIEF.md
# Transmit Descriptor Walker

This block moves outgoing frame data from memory to a byte stream under control of a descriptor ring. Software builds a ring of 8-byte descriptors, each naming one buffer and carrying ownership and framing flags. It then pulses the activate input while the controller is enabled. The walker reads descriptors through a 32-bit memory master port and copies each buffer byte by byte onto the output stream. It gives every consumed descriptor back to software by writing it back with its ownership bit cleared, then moves on along the ring.

A frame may span several buffers. The final byte of a frame leaves with a last marker, and frames longer than the frame limit are cut short and flagged. A walk ends at the first descriptor still owned by software, or after a fixed number of descriptors. The current ring position is kept, so the next activation carries on from there. Ring-base writes are accepted only while no walk is in progress.

Top module: `txdesc_walker`

## Requirements
- R1: A descriptor at word address P has flags in bits 31:16 and length in bits 15:0 of the word at P, and the buffer start address in the word at P+4. Within a memory word, the byte at address A sits in bits 31-8*(A mod 4) down to 24-8*(A mod 4), so the lowest address is the most significant byte. Buffer addresses need not be aligned.
- R2: A walk starts only when `txActivate` is pulsed while `cfgEnable` is high and no walk is in progress. With `cfgEnable` low, a pulse issues no memory request.
- R3: A walk ends at the first descriptor whose flag bit 15 (hardware-owned) is clear. That descriptor is not written back, and the next activation begins by reading it again.
- R4: Each consumed descriptor is written back at address P with flag bit 15 cleared, all other flag bits unchanged and the length unchanged. One `evTxBuf` pulse follows each write-back.
- R5: Buffer bytes are streamed in address order, and frames are gathered across descriptors. When a descriptor with flag bit 11 (last-in-frame) is consumed, the final byte of the frame carries `outLast`, one `evTxFrame` pulse is raised and the frame byte count restarts. A frame with no bytes still raises `evTxFrame`.
- R6: A frame never carries more than MAX_FRAME bytes. A descriptor whose length exceeds the room left in the frame is copied only up to that room and raises one `evBabble` pulse.
- R7: After a descriptor with flag bit 13 (wrap) is consumed, the next descriptor is read from the ring base. Otherwise the next one is read at P+8.
- R8: A ring-base write stores the value with bits 1:0 forced to zero and moves the current descriptor pointer to that base.
- R9: At most MAX_DESC descriptors are consumed per activation. The pointer then rests on the next descriptor, and a new activation resumes there.
- R10: While `outValid` is high and `outReady` is low, `outValid`, `outData` and `outLast` hold their values. A memory request likewise holds its address and direction until `memAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 1 | Controller enable; activations are ignored while low |
| txActivate | input | 1 | One-cycle pulse that starts a walk |
| ringBaseWr | input | 1 | Ring-base write strobe, honoured only while idle |
| ringBaseData | input | 32 | Ring-base value |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | Request is a write (descriptor write-back) |
| memAddr | output | 32 | Word address of the request (bits 1:0 zero) |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | One-cycle completion of the pending request |
| outValid | output | 1 | Stream byte valid |
| outData | output | 8 | Stream byte |
| outLast | output | 1 | Final byte of a frame |
| outReady | input | 1 | Stream sink accepts the byte |
| evTxBuf | output | 1 | Pulse: a descriptor was handed back |
| evTxFrame | output | 1 | Pulse: a frame completed |
| evBabble | output | 1 | Pulse: a buffer was truncated at the frame limit |

## Verification
A wrong ring pointer shows up at once as a wrong first request address, and then as wrong bytes or a missing write-back in the memory image once the walk ends. A stale frame byte count shows up in the very next frame, either as early truncation and a surplus `evBabble` or as a frame longer than the limit. Errors in the held last byte show up as a missing or misplaced `outLast` on the byte that closes a frame. This is most visible when the last descriptor copies no bytes, because the marker must then land on a byte from an earlier buffer.

// File: rtl/txw_pkg.sv
package txw_pkg;
  localparam int READY_BIT = 15;
  localparam int WRAP_BIT  = 13;
  localparam int LAST_BIT  = 11;

  typedef enum logic [1:0] {SEL_HEAD, SEL_PTR, SEL_DATA} memSelT;

  typedef struct packed {
    logic   ldHead;
    logic   ldPtr;
    logic   ldByte;
    logic   pushHeld;
    logic   clrHeld;
    logic   clrFrame;
    logic   advRing;
    logic   clrDesc;
    memSelT memSel;
  } dpStrobeT;
endpackage

// File: rtl/txw_datapath.sv
module txw_datapath
  import txw_pkg::*;
#(
  parameter int MAX_FRAME = 2032,
  parameter int MAX_DESC  = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobeT    stb,
  input  logic        baseWr,
  input  logic [31:0] baseData,
  input  logic [31:0] memRdata,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  output logic [7:0]  heldByte,
  output logic        heldValid,
  output logic        descReady,
  output logic        descLast,
  output logic        copyDone,
  output logic        descLimit,
  output logic        evBabble
);
  localparam int FCNT_W = $clog2(MAX_FRAME + 1);
  localparam int DCNT_W = $clog2(MAX_DESC + 1);
  localparam int CMP_W  = ((FCNT_W > 16) ? FCNT_W : 16) + 1;

  logic [31:0]       ringBase, curPtr, bufAddr;
  logic [15:0]       flags, len, copyLeft;
  logic [FCNT_W-1:0] frameCnt;
  logic [DCNT_W-1:0] descCnt;
  logic [7:0]        byteReg, fetched;
  logic [CMP_W-1:0]  room;
  logic              overflow;

  assign room     = CMP_W'(MAX_FRAME) - CMP_W'(frameCnt);
  assign overflow = CMP_W'(len) > room;

  always_comb begin
    case (bufAddr[1:0])
      2'd0:    fetched = memRdata[31:24];
      2'd1:    fetched = memRdata[23:16];
      2'd2:    fetched = memRdata[15:8];
      default: fetched = memRdata[7:0];
    endcase
  end

  always_comb begin
    case (stb.memSel)
      SEL_PTR:  memAddr = curPtr + 32'd4;
      SEL_DATA: memAddr = {bufAddr[31:2], 2'b00};
      default:  memAddr = curPtr;
    endcase
  end

  assign memWdata  = {flags & ~(16'h1 << READY_BIT), len};
  assign descReady = flags[READY_BIT];
  assign descLast  = flags[LAST_BIT];
  assign copyDone  = (copyLeft == 16'd0);
  assign descLimit = (descCnt == DCNT_W'(MAX_DESC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ringBase  <= '0;
      curPtr    <= '0;
      bufAddr   <= '0;
      flags     <= '0;
      len       <= '0;
      copyLeft  <= '0;
      frameCnt  <= '0;
      descCnt   <= '0;
      byteReg   <= '0;
      heldByte  <= '0;
      heldValid <= 1'b0;
      evBabble  <= 1'b0;
    end else begin
      if (baseWr) begin
        ringBase <= baseData & ~32'h3;
        curPtr   <= baseData & ~32'h3;
      end else if (stb.advRing) begin
        curPtr <= flags[WRAP_BIT] ? ringBase : curPtr + 32'd8;
      end
      if (stb.ldHead) {flags, len} <= memRdata;
      evBabble <= stb.ldPtr && overflow;
      if (stb.ldPtr) begin
        bufAddr  <= memRdata;
        copyLeft <= overflow ? 16'(room) : len;
      end
      if (stb.ldByte) byteReg <= fetched;
      if (stb.pushHeld) begin
        heldByte  <= byteReg;
        heldValid <= 1'b1;
        bufAddr   <= bufAddr + 32'd1;
        copyLeft  <= copyLeft - 16'd1;
        frameCnt  <= frameCnt + FCNT_W'(1);
      end
      if (stb.clrHeld)  heldValid <= 1'b0;
      if (stb.clrFrame) frameCnt  <= '0;
      if (stb.clrDesc)      descCnt <= '0;
      else if (stb.advRing) descCnt <= descCnt + DCNT_W'(1);
    end
  end

  AST_FRAME_CAP: assert property (@(posedge clk) disable iff (!rstN)
    frameCnt <= FCNT_W'(MAX_FRAME)); // R6
  AST_PTR_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    curPtr[1:0] == 2'b00); // R8
  AST_DESC_CAP: assert property (@(posedge clk) disable iff (!rstN)
    descCnt <= DCNT_W'(MAX_DESC)); // R9
endmodule

// File: rtl/txw_control.sv
module txw_control
  import txw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgEnable,
  input  logic     txActivate,
  input  logic     memAck,
  input  logic     outReady,
  input  logic     descReady,
  input  logic     descLast,
  input  logic     copyDone,
  input  logic     descLimit,
  input  logic     heldValid,
  output dpStrobeT stb,
  output logic     memReq,
  output logic     memWe,
  output logic     outValid,
  output logic     outLast,
  output logic     evTxBuf,
  output logic     evTxFrame,
  output logic     idle
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_HEAD, ST_CHECK, ST_RD_PTR, ST_COPY,
    ST_FETCH, ST_PUT, ST_WRBACK, ST_FLUSH, ST_ADV
  } stateT;

  stateT state, nxt;

  always_comb begin
    stb      = '0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    outValid = 1'b0;
    outLast  = 1'b0;
    nxt      = state;
    case (state)
      ST_IDLE: if (txActivate && cfgEnable) begin
        stb.clrDesc = 1'b1;
        nxt = ST_RD_HEAD;
      end
      ST_RD_HEAD: begin
        memReq = 1'b1;
        if (memAck) begin stb.ldHead = 1'b1; nxt = ST_CHECK; end
      end
      ST_CHECK: nxt = descReady ? ST_RD_PTR : ST_IDLE;
      ST_RD_PTR: begin
        memReq = 1'b1;
        stb.memSel = SEL_PTR;
        if (memAck) begin stb.ldPtr = 1'b1; nxt = ST_COPY; end
      end
      ST_COPY: nxt = copyDone ? ST_WRBACK : ST_FETCH;
      ST_FETCH: begin
        memReq = 1'b1;
        stb.memSel = SEL_DATA;
        if (memAck) begin stb.ldByte = 1'b1; nxt = ST_PUT; end
      end
      ST_PUT: begin
        outValid = heldValid;
        if (!heldValid || outReady) begin
          stb.pushHeld = 1'b1;
          nxt = ST_COPY;
        end
      end
      ST_WRBACK: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          if (descLast && heldValid) nxt = ST_FLUSH;
          else begin
            stb.clrFrame = descLast;
            nxt = ST_ADV;
          end
        end
      end
      ST_FLUSH: begin
        outValid = 1'b1;
        outLast  = 1'b1;
        if (outReady) begin
          stb.clrHeld  = 1'b1;
          stb.clrFrame = 1'b1;
          nxt = ST_ADV;
        end
      end
      ST_ADV: begin
        stb.advRing = 1'b1;
        nxt = descLimit ? ST_IDLE : ST_RD_HEAD;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      evTxBuf   <= 1'b0;
      evTxFrame <= 1'b0;
    end else begin
      state     <= nxt;
      evTxBuf   <= (state == ST_WRBACK) && memAck;
      evTxFrame <= ((state == ST_WRBACK) && memAck && descLast && !heldValid)
                || ((state == ST_FLUSH) && outReady);
    end
  end

  assign idle = (state == ST_IDLE);

  AST_BUF_AFTER_WB: assert property (@(posedge clk) disable iff (!rstN)
    evTxBuf |-> $past(memReq && memWe && memAck)); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outLast)); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWe)); // R10
endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
  import txw_pkg::*;
#(
  parameter int MAX_FRAME = 2032,
  parameter int MAX_DESC  = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgEnable,
  input  logic        txActivate,
  input  logic        ringBaseWr,
  input  logic [31:0] ringBaseData,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  input  logic        memAck,
  output logic        outValid,
  output logic [7:0]  outData,
  output logic        outLast,
  input  logic        outReady,
  output logic        evTxBuf,
  output logic        evTxFrame,
  output logic        evBabble
);
  dpStrobeT stb;
  logic heldValid, descReady, descLast, copyDone, descLimit, idle;

  txw_control u_ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .txActivate(txActivate),
    .memAck(memAck), .outReady(outReady), .descReady(descReady),
    .descLast(descLast), .copyDone(copyDone), .descLimit(descLimit),
    .heldValid(heldValid), .stb(stb), .memReq(memReq), .memWe(memWe),
    .outValid(outValid), .outLast(outLast), .evTxBuf(evTxBuf),
    .evTxFrame(evTxFrame), .idle(idle)
  );

  txw_datapath #(.MAX_FRAME(MAX_FRAME), .MAX_DESC(MAX_DESC)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .baseWr(ringBaseWr && idle),
    .baseData(ringBaseData), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .heldByte(outData), .heldValid(heldValid),
    .descReady(descReady), .descLast(descLast), .copyDone(copyDone),
    .descLimit(descLimit), .evBabble(evBabble)
  );

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr)); // R10
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outData)); // R10
endmodule

// File: tb/sim_txdesc_walker.sv
module sim_txdesc_walker;
  localparam int MAXF = 20;
  localparam int MAXD = 6;

  logic clk = 1'b0, rstN = 1'b0, cfgEnable = 1'b0, txActivate = 1'b0;
  logic ringBaseWr = 1'b0, memAck = 1'b0, outReady = 1'b0;
  logic [31:0] ringBaseData = '0, memRdata = '0;
  logic memReq, memWe, outValid, outLast, evTxBuf, evTxFrame, evBabble;
  logic [31:0] memAddr, memWdata;
  logic [7:0] outData;

  txdesc_walker #(.MAX_FRAME(MAXF), .MAX_DESC(MAXD)) u0 (.*);

  always #10 clk = ~clk;

  logic [31:0] mem [0:255];
  logic [31:0] refMem [0:255];
  int checks = 0, fails = 0, cyc = 0;
  int expQ[$], gotQ[$];
  int gotBuf, gotFrame, gotBab, expBuf, expFrame, expBab;
  int reqSeen, lat, holdErr;
  bit firstSeen, stalled;
  logic [31:0] firstAddr;
  logic [8:0] stallVal;
  int mPtr, mBase, mFrame;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model and stream sink, all at the falling edge
  always @(negedge clk) begin
    if (stalled) begin
      if (!(outValid && {outLast, outData} == stallVal)) holdErr++;
    end
    outReady = ($urandom % 4) != 0;
    stalled  = outValid && !outReady;
    stallVal = {outLast, outData};
    if (outValid && outReady) gotQ.push_back({23'd0, outLast, outData});
    if (evTxBuf) gotBuf++;
    if (evTxFrame) gotFrame++;
    if (evBabble) gotBab++;
    if (memReq) begin
      reqSeen++;
      if (!firstSeen) begin firstSeen = 1; firstAddr = memAddr; end
    end
    if (memAck) begin
      memAck = 1'b0;
      lat = $urandom % 3;
    end else if (memReq) begin
      if (lat == 0) begin
        if (memWe) mem[memAddr[9:2]] = memWdata;
        else memRdata = mem[memAddr[9:2]];
        memAck = 1'b1;
      end else lat--;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int byteAt(input int a);
    logic [31:0] w = refMem[a[9:2]];
    return int'((w >> (8 * (3 - a[1:0]))) & 32'hFF);
  endfunction

  task automatic putDesc(input int a, input int flg, input int ln, input int bufA);
    mem[a[9:2]]     = {flg[15:0], ln[15:0]};
    mem[a[9:2] + 1] = bufA;
  endtask

  task automatic setBase(input int a);
    @(negedge clk);
    ringBaseWr = 1'b1; ringBaseData = a;
    @(negedge clk);
    ringBaseWr = 1'b0;
    mBase = a & ~3; mPtr = mBase;
  endtask

  // reference walk from the requirements, on a copy of memory
  task automatic modelWalk();
    int cnt = 0;
    while (cnt < MAXD) begin
      logic [31:0] w0 = refMem[mPtr[9:2]];
      int ln, n, bufA;
      if (!w0[31]) break;
      ln = int'(w0[15:0]);
      bufA = refMem[mPtr[9:2] + 1];
      n = ln;
      if (ln > MAXF - mFrame) begin n = MAXF - mFrame; expBab++; end
      for (int i = 0; i < n; i++) expQ.push_back(byteAt(bufA + i));
      mFrame += n;
      refMem[mPtr[9:2]] = w0 & ~32'h8000_0000;
      expBuf++;
      if (w0[27]) begin
        if (mFrame > 0) expQ[expQ.size() - 1] |= 32'h100;
        expFrame++;
        mFrame = 0;
      end
      mPtr = w0[29] ? mBase : mPtr + 8;
      cnt++;
    end
  endtask

  task automatic waitQuiet();
    int idleCnt = 0;
    while (idleCnt < 30) begin
      @(negedge clk);
      if (memReq || outValid) idleCnt = 0; else idleCnt++;
    end
  endtask

  task automatic runAct(input string tag);
    int badIdx = -1, mIdx = -1;
    refMem = mem;
    expQ.delete(); gotQ.delete();
    expBuf = 0; expFrame = 0; expBab = 0;
    gotBuf = 0; gotFrame = 0; gotBab = 0; holdErr = 0;
    modelWalk();
    firstSeen = 0;
    @(negedge clk); cfgEnable = 1'b1; txActivate = 1'b1;
    @(negedge clk); txActivate = 1'b0;
    waitQuiet();
    foreach (expQ[i]) if (badIdx < 0 && (i >= gotQ.size() || gotQ[i] != expQ[i])) badIdx = i;
    if (badIdx < 0 && gotQ.size() != expQ.size()) badIdx = expQ.size();
    check(badIdx < 0, {tag, " R1/R5 stream bytes and last marker"},
          (badIdx >= 0 && badIdx < gotQ.size()) ? gotQ[badIdx] : gotQ.size(),
          (badIdx >= 0 && badIdx < expQ.size()) ? expQ[badIdx] : expQ.size());
    check(gotBuf == expBuf, {tag, " R4 evTxBuf count"}, gotBuf, expBuf);
    check(gotFrame == expFrame, {tag, " R5 evTxFrame count"}, gotFrame, expFrame);
    check(gotBab == expBab, {tag, " R6 evBabble count"}, gotBab, expBab);
    for (int i = 0; i < 256; i++) if (mIdx < 0 && mem[i] != refMem[i]) mIdx = i;
    check(mIdx < 0, {tag, " R4 memory image after write-back"},
          mIdx < 0 ? 0 : int'(mem[mIdx]), mIdx < 0 ? 0 : int'(refMem[mIdx]));
    check(holdErr == 0, {tag, " R10 stream held while stalled"}, holdErr, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    mFrame = 0;
    repeat (3) @(negedge clk);
    check(!memReq && !outValid && !evTxBuf && !evTxFrame && !evBabble,
          "reset R2 outputs quiet", {memReq, outValid, evTxBuf, evTxFrame, evBabble}, 0);
    rstN = 1'b1;

    // directed: two-buffer frame, unaligned buffers, stop at software-owned
    putDesc(32'h100, 32'h8000, 3, 32'h201);
    putDesc(32'h108, 32'h8800, 2, 32'h2FE);
    putDesc(32'h110, 32'h0000, 4, 32'h240);
    setBase(32'h103);

    // disabled activation does nothing
    reqSeen = 0;
    @(negedge clk); cfgEnable = 1'b0; txActivate = 1'b1;
    @(negedge clk); txActivate = 1'b0;
    repeat (20) @(negedge clk);
    check(reqSeen == 0, "R2 no request while disabled", reqSeen, 0);

    runAct("multi-buffer");
    check(firstAddr == 32'h100, "R8 base low bits cleared", firstAddr, 32'h100);
    check(expQ.size() == 5, "R5 gathered frame length", expQ.size(), 5);
    runAct("stopped");
    check(firstAddr == 32'h110, "R3 resumes at software-owned descriptor", firstAddr, 32'h110);
    check(mem[32'h110 >> 2] == 32'h0000_0004, "R3 stop descriptor untouched", mem[32'h110 >> 2], 32'h4);

    // wrap: descriptor after the wrapping one must stay untouched
    putDesc(32'h040, 32'hA800, 2, 32'h260);
    putDesc(32'h048, 32'h8800, 1, 32'h270);
    setBase(32'h040);
    runAct("wrap");
    check(mem[32'h048 >> 2][31] == 1'b1, "R7 wrap returns to base", mem[32'h048 >> 2], 32'h8800_0001);

    // truncation, empty frame, frame ending with a zero-copy buffer
    putDesc(32'h000, 32'h8000, 15, 32'h300);
    putDesc(32'h008, 32'h8800, 10, 32'h320);
    putDesc(32'h010, 32'h8800, 0, 32'h330);
    putDesc(32'h018, 32'h8000, 25, 32'h340);
    putDesc(32'h020, 32'h8800, 3, 32'h360);
    putDesc(32'h028, 32'h0000, 0, 32'h370);
    setBase(32'h000);
    runAct("truncate");
    check(expBab == 3 && expQ.size() == 40, "R6 truncation model", expQ.size(), 40);

    // per-activation descriptor limit
    for (int i = 0; i < 8; i++) putDesc(32'h080 + 8 * i, 32'h8800, 1, 32'h380 + i);
    putDesc(32'h0C0, 32'h0000, 0, 32'h390);
    setBase(32'h080);
    runAct("limit-a");
    check(gotBuf == MAXD, "R9 limit per activation", gotBuf, MAXD);
    runAct("limit-b");
    check(firstAddr == 32'h080 + 8 * MAXD, "R9 resume after limit", firstAddr, 32'h080 + 8 * MAXD);
    check(gotBuf == 8 - MAXD, "R9 remainder consumed", gotBuf, 8 - MAXD);

    // constrained random rings
    for (int r = 0; r < 20; r++) begin
      int n = 1 + $urandom % 5;
      for (int i = 0; i < 256; i++) if (i >= 128) mem[i] = $urandom;
      for (int i = 0; i < n; i++) begin
        int flg = 32'h8000 | ((i == n - 1 || ($urandom % 2) == 1) ? 32'h0800 : 0);
        putDesc(32'h100 + 8 * i, flg, $urandom % 9, 32'h200 + $urandom % 480);
      end
      putDesc(32'h100 + 8 * n, 32'h0000, 0, 32'h200);
      setBase(32'h100);
      runAct($sformatf("random-%0d", r));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule